// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Emulator

This block is a clocked model of a byte-wide parallel EEPROM with active-low chip, output and write enables. The enables are synchronized to the system clock. The block recovers read, standby, byte-write, page-write and chip-erase behaviour from those strobes. Written bytes first collect in a 32-byte page buffer. When no further byte arrives within a quiet window, a program phase copies the buffered bytes into the array. The part reports busy for a programmable number of cycles while it does this.

A host reads by pulling chip and output enable low and then sampling the data output while the output-enable flag is high. Writes are strobed with chip and write enable while output enable stays high. Any number of bytes in one page may be loaded, in any order, before the quiet window expires. Raising the high-voltage flag with chip and write enable low and the data lines all ones clears the whole array. The array depth is set by `ADDR_W`; the full 8K part uses 13.

Top module: `eeprom_page_emu`

## Requirements
- R1: With chip enable and output enable both low, `dataOe` is high and `dataOut` carries the byte stored at `addrIn` (while not busy).
- R2: With chip enable high, `dataOe` is low whatever the state of output enable.
- R3: A single byte strobed with chip and write enable low and output enable high is readable at its address once the busy period that follows it has ended.
- R4: Bytes loaded in random order into one page are all committed in a single program phase; bytes of that page that were not loaded keep their previous value.
- R5: The address is taken when the later of chip enable and write enable falls; address changes before that moment do not matter.
- R6: The data byte is taken at the end of the write pulse, when the first strobe rises; earlier values on `dataIn` during the pulse are not stored.
- R7: Programming starts only after `TIMEOUT_CYC` cycles with no accepted byte load; `busy` stays low while that window runs and then goes high.
- R8: `busy` stays high for `WRITE_CYC` cycles for a page program and for one cycle per array byte for a chip erase, and then falls.
- R9: Write strobes that arrive while `busy` is high are ignored and start no later program phase.
- R10: While `busy` is high, a read returns the complement of bit 7 of the last accepted byte on `dataOut[7]`, with bits 6..0 zero.
- R11: After the first byte of a buffer is loaded, a byte addressed to a different page (address bits ADDR_W-1..5) is dropped.
- R12: No byte is loaded when output enable is low during the write strobes.
- R13: With `hvOe` high, chip and write enable low and `dataIn` equal to 8'hFF, the whole array becomes 8'hFF whatever the address. With any other `dataIn`, no erase takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | ADDR_W | Byte address; bits ADDR_W-1..5 pick the page |
| dataIn | input | 8 | Write data from the host |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| hvOe | input | 1 | High-voltage level present on output enable (erase request) |
| dataOut | output | 8 | Read data |
| dataOe | output | 1 | High when the host bus should be driven from `dataOut` |
| busy | output | 1 | High during a page program or a chip erase |

## Verification
The bench moves the address between the falling edges of the two strobes and changes the data inside a pulse. A model that latches at the wrong edge then writes to the first address or stores the stale byte. It loads a second page into a filling buffer and strobes during busy. A design that lets the page move or accepts writes while busy then corrupts a foreign byte or starts a second program phase. It also checks that unloaded bytes of a page survive a commit, which catches a page program that rewrites the whole row from a stale buffer. Finally, an erase request whose data is not all ones must leave the array untouched.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG,
    ST_ERASE
  } eeState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic latchAddr;
    logic loadReq;
    logic progWr;
    logic eraseWr;
    logic clearBuf;
    logic startErase;
    logic busy;
  } eeStrobe_t;

endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 5,
  parameter int TIMEOUT_CYC = 200,
  parameter int WRITE_CYC   = 600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              hvOe,
  input  logic [7:0]        dataIn,
  input  logic              pageOk,
  output eeStrobe_t         st,
  output logic [ADDR_W-1:0] seqAddr,
  output logic              dataOe
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PAGE    = 1 << PAGE_W;
  localparam int SEQ_MAX = (WRITE_CYC > DEPTH) ? WRITE_CYC : DEPTH;
  localparam int SEQ_W   = $clog2(SEQ_MAX + 1);
  localparam int TMO_W   = $clog2(TIMEOUT_CYC + 1);
  localparam logic [SEQ_W-1:0] SEQ_WR_END = SEQ_W'(WRITE_CYC - 1);
  localparam logic [SEQ_W-1:0] SEQ_ER_END = SEQ_W'(DEPTH - 1);
  localparam logic [SEQ_W-1:0] SEQ_PAGE   = SEQ_W'(PAGE);
  localparam logic [TMO_W-1:0] TMO_END    = TMO_W'(TIMEOUT_CYC - 1);

  logic [1:0] ceSync, oeSync, weSync, hvSync;
  logic       ceS, oeS, weS, hvS;
  logic       writeActive, eraseActive, wrPrev, erPrev;
  logic       wrRise, wrFall, erRise, armed, busyInt;
  eeState_t   state;
  logic [SEQ_W-1:0] seq;
  logic [TMO_W-1:0] tmo;

  // two-flop synchronizers on every strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceSync <= 2'b11;
      oeSync <= 2'b11;
      weSync <= 2'b11;
      hvSync <= 2'b00;
    end else begin
      ceSync <= {ceSync[0], ceN};
      oeSync <= {oeSync[0], oeN};
      weSync <= {weSync[0], weN};
      hvSync <= {hvSync[0], hvOe};
    end
  end

  assign ceS = ceSync[1];
  assign oeS = oeSync[1];
  assign weS = weSync[1];
  assign hvS = hvSync[1];

  assign writeActive = !ceS && !weS && oeS && !hvS;
  assign eraseActive = !ceS && !weS && hvS && (dataIn == 8'hFF);
  assign wrRise  = writeActive && !wrPrev;
  assign wrFall  = !writeActive && wrPrev;
  assign erRise  = eraseActive && !erPrev;
  assign busyInt = (state == ST_PROG) || (state == ST_ERASE);
  assign dataOe  = !ceS && !oeS;
  assign seqAddr = seq[ADDR_W-1:0];

  always_comb begin
    st            = '0;
    st.busy       = busyInt;
    st.latchAddr  = wrRise && !busyInt;
    st.loadReq    = wrFall && armed && !busyInt;
    st.progWr     = (state == ST_PROG) && (seq < SEQ_PAGE);
    st.eraseWr    = (state == ST_ERASE);
    st.clearBuf   = (state == ST_PROG) && (seq == SEQ_WR_END);
    st.startErase = erRise && (state == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev <= 1'b0;
      erPrev <= 1'b0;
      armed  <= 1'b0;
      state  <= ST_IDLE;
      seq    <= '0;
      tmo    <= '0;
    end else begin
      wrPrev <= writeActive;
      erPrev <= eraseActive;
      if (busyInt || wrFall)   armed <= 1'b0;
      else if (wrRise)         armed <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (st.startErase) begin
            state <= ST_ERASE;
            seq   <= '0;
          end else if (st.loadReq && pageOk) begin
            state <= ST_LOAD;
            tmo   <= '0;
          end
        end
        ST_LOAD: begin
          if (st.loadReq && pageOk) begin
            tmo <= '0;
          end else if (tmo == TMO_END) begin
            state <= ST_PROG;
            seq   <= '0;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        ST_PROG: begin
          if (seq == SEQ_WR_END) state <= ST_IDLE;
          else                   seq   <= seq + 1'b1;
        end
        ST_ERASE: begin
          if (seq == SEQ_ER_END) state <= ST_IDLE;
          else                   seq   <= seq + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  eeStrobe_t         st,
  input  logic [ADDR_W-1:0] seqAddr,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  output logic              pageOk,
  output logic [7:0]        dataOut
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] addrLatch;
  logic [PG_W-1:0]   pageReg;
  logic [7:0]        pageBuf [PAGE];
  logic [PAGE-1:0]   loadedMask;
  logic [7:0]        lastByte;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        rdData;
  logic [PAGE_W-1:0] byteIdx, progIdx;
  logic              loadHit;

  assign byteIdx = addrLatch[PAGE_W-1:0];
  assign progIdx = seqAddr[PAGE_W-1:0];
  assign pageOk  = !(|loadedMask) || (addrLatch[ADDR_W-1:PAGE_W] == pageReg);
  assign loadHit = st.loadReq && pageOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLatch <= '0;
      pageReg   <= '0;
      lastByte  <= '0;
    end else begin
      if (st.latchAddr) addrLatch <= addrIn;
      if (loadHit) begin
        lastByte <= dataIn;
        if (!(|loadedMask)) pageReg <= addrLatch[ADDR_W-1:PAGE_W];
      end else if (st.startErase) begin
        lastByte <= 8'hFF;
      end
    end
  end

  // one flag and one data byte per page slot
  for (genvar i = 0; i < PAGE; i++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   loadedMask[i] <= 1'b0;
      else if (st.clearBuf)                        loadedMask[i] <= 1'b0;
      else if (loadHit && byteIdx == PAGE_W'(i))   loadedMask[i] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (loadHit && byteIdx == PAGE_W'(i)) pageBuf[i] <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (st.eraseWr)
      mem[seqAddr] <= 8'hFF;
    else if (st.progWr && loadedMask[progIdx])
      mem[{pageReg, progIdx}] <= pageBuf[progIdx];
    rdData <= mem[addrIn];
  end

  assign dataOut = st.busy ? {~lastByte[7], 7'b0} : rdData;

endmodule

// File: rtl/eeprom_page_emu.sv
module eeprom_page_emu
  import eeprom_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int TIMEOUT_CYC = 200,
  parameter int WRITE_CYC   = 600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [7:0]        dataIn,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              hvOe,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output logic              busy
);

  localparam int PAGE_W = 5;

  eeStrobe_t         st;
  logic [ADDR_W-1:0] seqAddr;
  logic              pageOk;

  eeprom_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
    .TIMEOUT_CYC(TIMEOUT_CYC), .WRITE_CYC(WRITE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .hvOe(hvOe),
    .dataIn(dataIn), .pageOk(pageOk), .st(st), .seqAddr(seqAddr), .dataOe(dataOe)
  );

  eeprom_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .seqAddr(seqAddr), .addrIn(addrIn),
    .dataIn(dataIn), .pageOk(pageOk), .dataOut(dataOut)
  );

  assign busy = st.busy;

endmodule

// File: rtl/eeprom_page_emu_chk.sv
module eeprom_page_emu_chk #(
  parameter int ADDR_W    = 11,
  parameter int WRITE_CYC = 600
) (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       oeN,
  input logic [7:0] dataOut,
  input logic       dataOe,
  input logic       busy
);

  localparam int DEPTH    = 1 << ADDR_W;
  localparam int MIN_BUSY = (WRITE_CYC < DEPTH) ? WRITE_CYC : DEPTH;

  logic [1:0] settle;
  int         busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settle  <= '0;
      busyLen <= 0;
    end else begin
      if (settle != 2'd3) settle <= settle + 1'b1;
      busyLen <= busy ? busyLen + 1 : 0;
    end
  end

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (settle == 2'd3 && $past(ceN, 2)) |-> !dataOe);  // R2

  AST_READ_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (settle == 2'd3 && !$past(ceN, 2) && !$past(oeN, 2)) |-> dataOe);  // R1

  AST_BUSY_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && dataOe) |-> (dataOut[6:0] == 7'd0));  // R10

  AST_BUSY_MIN_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen >= MIN_BUSY - 1));  // R8

endmodule

bind eeprom_page_emu eeprom_page_emu_chk #(.ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN),
  .dataOut(dataOut), .dataOe(dataOe), .busy(busy)
);

// File: tb/tb_eeprom_page_emu.sv
module tb_eeprom_page_emu;

  localparam int ADDR_W = 11;
  localparam int TMO    = 200;
  localparam int WCYC   = 600;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [7:0]        dataIn = '0;
  logic              ceN = 1'b1, oeN = 1'b1, weN = 1'b1, hvOe = 1'b0;
  logic [7:0]        dataOut;
  logic              dataOe, busy;

  int   total = 0;
  int   fails = 0;
  logic [7:0] expQ [$];
  string      tagQ [$];
  event       sampleEv;

  always #2 clk = ~clk;

  eeprom_page_emu #(.ADDR_W(ADDR_W), .TIMEOUT_CYC(TMO), .WRITE_CYC(WCYC)) dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn), .ceN(ceN),
    .oeN(oeN), .weN(weN), .hvOe(hvOe), .dataOut(dataOut), .dataOe(dataOe), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // monitor: pops the expected read value and compares
  initial begin
    forever begin
      @(sampleEv);
      begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        total++;
        if (dataOe !== 1'b1 || dataOut !== e) begin
          fails++;
          $display("FAIL %s: actual oe=%0b data=%0h expected oe=1 data=%0h", t, dataOe, dataOut, e);
        end
      end
    end
  end

  task automatic readExp(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addrIn = a; ceN = 1'b0; oeN = 1'b0;
    repeat (6) @(negedge clk);
    expQ.push_back(e);
    tagQ.push_back(tag);
    ->sampleEv;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wrByte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addrIn = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    repeat (4) @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic chipErase(input logic [7:0] d);
    @(negedge clk);
    hvOe = 1'b1; dataIn = d; ceN = 1'b0; weN = 1'b0;
    repeat (4) @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    repeat (3) @(negedge clk);
    hvOe = 1'b0;
  endtask

  task automatic waitLevel(input logic lvl, input int cap);
    for (int i = 0; i < cap && busy !== lvl; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 reset oe", dataOe, 0);
    check("R8 reset busy", busy, 0);

    // R13 chip erase
    chipErase(8'hFF);
    check("R13 erase busy", busy, 1);
    waitLevel(1'b0, 2200);
    check("R8 erase done", busy, 0);
    readExp(11'h000, 8'hFF, "R13 erased low");
    readExp(11'h7FF, 8'hFF, "R13 erased high");
    readExp(11'h123, 8'hFF, "R1 read erased");

    // R2 standby with oe low
    @(negedge clk); ceN = 1'b1; oeN = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 standby hiz", dataOe, 0);
    oeN = 1'b1;

    // R3/R7/R8/R10 single byte
    wrByte(11'h040, 8'h5A);
    repeat (100) @(negedge clk);
    check("R7 quiet window", busy, 0);
    waitLevel(1'b1, TMO + 20);
    check("R7 program start", busy, 1);
    readExp(11'h040, 8'h80, "R10 busy status");
    repeat (300) @(negedge clk);
    check("R8 still busy", busy, 1);
    waitLevel(1'b0, WCYC);
    check("R8 program end", busy, 0);
    readExp(11'h040, 8'h5A, "R3 byte written");

    // R4 random page load
    wrByte(11'h0A3, 8'h11);
    wrByte(11'h0A0, 8'h22);
    wrByte(11'h0BF, 8'h33);
    waitLevel(1'b1, TMO + 40);
    waitLevel(1'b0, WCYC + 10);
    readExp(11'h0A3, 8'h11, "R4 byte a3");
    readExp(11'h0A0, 8'h22, "R4 byte a0");
    readExp(11'h0BF, 8'h33, "R4 byte bf");
    readExp(11'h0A1, 8'hFF, "R4 unloaded kept");

    // R11 page locked
    wrByte(11'h100, 8'h44);
    wrByte(11'h125, 8'h55);
    waitLevel(1'b1, TMO + 40);
    waitLevel(1'b0, WCYC + 10);
    readExp(11'h100, 8'h44, "R11 first page");
    readExp(11'h125, 8'hFF, "R11 other page dropped");

    // R9 writes during busy
    wrByte(11'h200, 8'h81);
    waitLevel(1'b1, TMO + 40);
    wrByte(11'h200, 8'h0F);
    readExp(11'h210, 8'h00, "R10 busy status bit7 set");
    waitLevel(1'b0, WCYC + 10);
    repeat (2 * TMO) @(negedge clk);
    check("R9 no new program", busy, 0);
    readExp(11'h200, 8'h81, "R9 busy write ignored");

    // R12 oe low inhibits
    @(negedge clk);
    addrIn = 11'h300; dataIn = 8'h12; oeN = 1'b0; ceN = 1'b0; weN = 1'b0;
    repeat (4) @(negedge clk);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    repeat (TMO + 50) @(negedge clk);
    check("R12 no program", busy, 0);
    readExp(11'h300, 8'hFF, "R12 inhibited");

    // R5 address at later falling strobe
    @(negedge clk);
    addrIn = 11'h400; dataIn = 8'h66; weN = 1'b0;
    repeat (4) @(negedge clk);
    addrIn = 11'h401;
    repeat (2) @(negedge clk);
    ceN = 1'b0;
    repeat (4) @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    repeat (4) @(negedge clk);
    waitLevel(1'b1, TMO + 40);
    waitLevel(1'b0, WCYC + 10);
    readExp(11'h401, 8'h66, "R5 later edge address");
    readExp(11'h400, 8'hFF, "R5 early address unused");

    // R6 data at end of pulse
    @(negedge clk);
    addrIn = 11'h500; dataIn = 8'h01; ceN = 1'b0; weN = 1'b0;
    repeat (3) @(negedge clk);
    dataIn = 8'h77;
    repeat (3) @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    repeat (4) @(negedge clk);
    waitLevel(1'b1, TMO + 40);
    waitLevel(1'b0, WCYC + 10);
    readExp(11'h500, 8'h77, "R6 final data");

    // R13 erase refused without all-ones data
    chipErase(8'h7F);
    repeat (10) @(negedge clk);
    check("R13 no erase busy", busy, 0);
    readExp(11'h040, 8'h5A, "R13 array kept");

    chipErase(8'hFF);
    waitLevel(1'b1, 20);
    waitLevel(1'b0, 2200);
    readExp(11'h040, 8'hFF, "R13 second erase");
    readExp(11'h0A3, 8'hFF, "R13 second erase page");

    repeat (4) @(negedge clk);
    summary();
  end

endmodule